// File: doc/BRIEF.md
# Hierarchical Priority Hit Drain

This block drains hits from a small matrix of discriminator cells arranged in columns. Each cell watches one digital comparator output. On the first hit it arms a latch and records the value of a free-running timestamp counter. A three-step control sequence empties the matrix:

- A freeze strobe turns every armed latch into a readout flag.
- A column-load strobe lets each idle column pull its winning flagged cell into a one-entry column buffer. The winner is chosen by a ripple priority chain, lower row first, and the cell is cleared as it is taken.
- A column-read strobe lets a second ripple chain, lower column first, pick one full buffer. That buffer is emitted as a word holding column, row and timestamp, and then emptied.

Each cell also holds a small threshold trim register that can be written and read back by cell address. A sequencer alternates column-load and column-read until the empty flag rises. Hits that arrive after a freeze wait for the next freeze.

Top module: `hdr_top`

## Requirements
- R1: The timestamp counter resets to 0, advances by one on every clock and wraps modulo 2^TS_W. A hit stores the counter value present at the clock edge that samples it.
- R2: The first hit on an idle cell arms its latch. Further hits on an armed or flagged cell are ignored, and the first timestamp is kept until the cell is read.
- R3: The freeze strobe (ld_pix_i) turns armed latches into readout flags. A hit armed after a freeze is not reported until a later freeze.
- R4: On column load (ld_col_i), every column whose buffer is empty takes its lowest-row flagged cell and clears that cell.
- R5: On column read (rd_col_i), the lowest-index column with a full buffer is emitted and its buffer is emptied. At most one column is granted.
- R6: One cycle after a read that finds a full buffer, valid_o is high for one cycle. word_o = {column[COL_W], row[ROW_W], timestamp[TS_W]}, with the column in the most significant bits and the timestamp in the least.
- R7: A column read with no full buffer leaves valid_o low and word_o unchanged.
- R8: empty_o is high exactly when no cell holds a readout flag and no column buffer is full. Armed but unfrozen latches do not count.
- R9: A frozen set of hits drains with each hit reported exactly once, in ascending order of the flat index column*N_ROWS+row.
- R10: When trim_wr_i is high, trim_data_i is written into the cell addressed by (trim_col_i, trim_row_i). A trim_rd_i shows that cell's value on trim_data_o one cycle later. Trim registers reset to 0.
- R11: After reset, valid_o is 0, word_o is 0, empty_o is 1 and trim_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | N_COLS*N_ROWS | Comparator outputs, bit column*N_ROWS+row |
| ld_pix_i | input | 1 | Freeze armed latches into flags |
| ld_col_i | input | 1 | Load column buffers from cells |
| rd_col_i | input | 1 | Emit one column buffer |
| trim_wr_i | input | 1 | Trim write strobe |
| trim_rd_i | input | 1 | Trim read strobe |
| trim_col_i | input | COL_W | Trim column address |
| trim_row_i | input | ROW_W | Trim row address |
| trim_data_i | input | TRIM_W | Trim write data |
| trim_data_o | output | TRIM_W | Trim read data |
| word_o | output | COL_W+ROW_W+TS_W | Hit word |
| valid_o | output | 1 | Hit word strobe |
| empty_o | output | 1 | No pending flags or buffered hits |

## Verification
The bench targets several failure modes:

- **Readout order.** A design that refilled only after a full column drain, or that favoured higher rows, would emit the same hits in a different order.
- **Timestamps.** Hits are injected across a counter wrap and repeated on an already armed cell. A design that overwrote the stored stamp, or that failed to wrap, would report a stamp that disagrees with the cycle count.
- **Freeze boundary.** A hit is armed just after a freeze. A design that flagged it at once would report it early and would hold empty_o low.
- **Idle reads and trim access.** Reads on an empty matrix must not produce a strobe. Trim accesses to distinct cells must not alias.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  localparam int MAX_W = 64;

  // keep only the least significant set bit
  function automatic logic [MAX_W-1:0] lowest_one(input logic [MAX_W-1:0] v);
    return v & (~v + 64'd1);
  endfunction

  // increment modulo 2^w
  function automatic logic [MAX_W-1:0] wrap_inc(input logic [MAX_W-1:0] v, input int w);
    logic [MAX_W-1:0] m;
    m = (w >= MAX_W) ? '1 : ((64'd1 << w) - 64'd1);
    return (v + 64'd1) & m;
  endfunction
endpackage

// File: rtl/hdr_cell.sv
module hdr_cell #(
  parameter int TS_W   = 8,
  parameter int ROW_W  = 3,
  parameter int TRIM_W = 4,
  parameter int ROW_ID = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hit_i,
  input  logic [TS_W-1:0]         ts_i,
  input  logic                    ld_pix_i,
  input  logic                    take_i,
  input  logic                    chain_in_i,
  output logic                    chain_out_o,
  output logic                    grant_o,
  output logic                    flag_o,
  output logic [ROW_W+TS_W-1:0]   bus_o,
  input  logic                    trim_we_i,
  input  logic [TRIM_W-1:0]       trim_d_i,
  output logic [TRIM_W-1:0]       trim_q_o
);
  logic            latch_q, flag_q;
  logic [TS_W-1:0] ts_q;

  assign grant_o     = flag_q & ~chain_in_i;
  assign chain_out_o = flag_q | chain_in_i;
  assign flag_o      = flag_q;
  assign bus_o       = grant_o ? {ROW_W'(ROW_ID), ts_q} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= 1'b0;
      flag_q   <= 1'b0;
      ts_q     <= '0;
      trim_q_o <= '0;
    end else begin
      if (take_i) begin
        latch_q <= hit_i;
        flag_q  <= 1'b0;
        if (hit_i) ts_q <= ts_i;
      end else begin
        if (hit_i && !latch_q) begin
          latch_q <= 1'b1;
          ts_q    <= ts_i;
        end
        if (ld_pix_i && latch_q) flag_q <= 1'b1;
      end
      if (trim_we_i) trim_q_o <= trim_d_i;
    end
  end
endmodule

// File: rtl/hdr_column.sv
module hdr_column #(
  parameter int N_ROWS = 8,
  parameter int TS_W   = 8,
  parameter int ROW_W  = 3,
  parameter int TRIM_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_ROWS-1:0]          hits_i,
  input  logic [TS_W-1:0]            ts_i,
  input  logic                       ld_pix_i,
  input  logic                       ld_col_i,
  input  logic                       rd_i,
  output logic                       buf_v_o,
  output logic [ROW_W+TS_W-1:0]      buf_o,
  output logic [N_ROWS-1:0]          flags_o,
  input  logic [N_ROWS-1:0]          trim_we_i,
  input  logic [TRIM_W-1:0]          trim_d_i,
  output logic [N_ROWS*TRIM_W-1:0]   trim_q_o
);
  localparam int SLOT_W = ROW_W + TS_W;

  logic [N_ROWS:0]   chain;
  logic [N_ROWS-1:0] grant;
  logic [SLOT_W-1:0] bus    [N_ROWS];
  logic [SLOT_W-1:0] bus_or [N_ROWS+1];
  logic              load;

  assign chain[0]  = 1'b0;
  assign bus_or[0] = '0;
  assign load      = ld_col_i & ~buf_v_o & chain[N_ROWS];

  for (genvar r = 0; r < N_ROWS; r++) begin : g_cell
    hdr_cell #(.TS_W(TS_W), .ROW_W(ROW_W), .TRIM_W(TRIM_W), .ROW_ID(r)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hits_i[r]),
      .ts_i       (ts_i),
      .ld_pix_i   (ld_pix_i),
      .take_i     (load & grant[r]),
      .chain_in_i (chain[r]),
      .chain_out_o(chain[r+1]),
      .grant_o    (grant[r]),
      .flag_o     (flags_o[r]),
      .bus_o      (bus[r]),
      .trim_we_i  (trim_we_i[r]),
      .trim_d_i   (trim_d_i),
      .trim_q_o   (trim_q_o[r*TRIM_W +: TRIM_W])
    );
    assign bus_or[r+1] = bus_or[r] | bus[r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_v_o <= 1'b0;
      buf_o   <= '0;
    end else if (load) begin
      buf_v_o <= 1'b1;
      buf_o   <= bus_or[N_ROWS];
    end else if (rd_i) begin
      buf_v_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_top.sv
module hdr_top #(
  parameter int N_COLS = 4,
  parameter int N_ROWS = 8,
  parameter int TS_W   = 8,
  parameter int TRIM_W = 4,
  localparam int ROW_W   = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int COL_W   = (N_COLS > 1) ? $clog2(N_COLS) : 1,
  localparam int SLOT_W  = ROW_W + TS_W,
  localparam int WORD_W  = COL_W + SLOT_W,
  localparam int N_CELLS = N_COLS * N_ROWS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_CELLS-1:0]   hit_i,
  input  logic                 ld_pix_i,
  input  logic                 ld_col_i,
  input  logic                 rd_col_i,
  input  logic                 trim_wr_i,
  input  logic                 trim_rd_i,
  input  logic [COL_W-1:0]     trim_col_i,
  input  logic [ROW_W-1:0]     trim_row_i,
  input  logic [TRIM_W-1:0]    trim_data_i,
  output logic [TRIM_W-1:0]    trim_data_o,
  output logic [WORD_W-1:0]    word_o,
  output logic                 valid_o,
  output logic                 empty_o
);
  import hdr_pkg::*;

  logic [TS_W-1:0]           ts_q;
  logic [N_COLS-1:0]         buf_v;
  logic [N_COLS-1:0]         col_grant;
  logic [N_COLS:0]           cchain;
  logic [SLOT_W-1:0]         col_buf [N_COLS];
  logic [WORD_W-1:0]         cbus_or [N_COLS+1];
  logic [N_CELLS-1:0]        flag_all;
  logic [N_CELLS-1:0]        trim_we;
  logic [N_CELLS*TRIM_W-1:0] trim_all;
  int                        trim_idx;

  assign cchain[0]  = 1'b0;
  assign cbus_or[0] = '0;
  assign empty_o    = ~cchain[N_COLS] & ~|flag_all;
  assign trim_idx   = int'(trim_col_i) * N_ROWS + int'(trim_row_i);

  always_ff @(posedge clk) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= TS_W'(wrap_inc(MAX_W'(ts_q), TS_W));
  end

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    for (genvar r = 0; r < N_ROWS; r++) begin : g_we
      assign trim_we[c*N_ROWS+r] = trim_wr_i && (trim_col_i == COL_W'(c))
                                   && (trim_row_i == ROW_W'(r));
    end

    hdr_column #(.N_ROWS(N_ROWS), .TS_W(TS_W), .ROW_W(ROW_W), .TRIM_W(TRIM_W)) u_col (
      .clk      (clk),
      .rst_n    (rst_n),
      .hits_i   (hit_i[c*N_ROWS +: N_ROWS]),
      .ts_i     (ts_q),
      .ld_pix_i (ld_pix_i),
      .ld_col_i (ld_col_i),
      .rd_i     (rd_col_i & col_grant[c]),
      .buf_v_o  (buf_v[c]),
      .buf_o    (col_buf[c]),
      .flags_o  (flag_all[c*N_ROWS +: N_ROWS]),
      .trim_we_i(trim_we[c*N_ROWS +: N_ROWS]),
      .trim_d_i (trim_data_i),
      .trim_q_o (trim_all[c*N_ROWS*TRIM_W +: N_ROWS*TRIM_W])
    );

    assign col_grant[c] = buf_v[c] & ~cchain[c];
    assign cchain[c+1]  = buf_v[c] | cchain[c];
    assign cbus_or[c+1] = cbus_or[c] | (col_grant[c] ? {COL_W'(c), col_buf[c]} : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_o      <= '0;
      valid_o     <= 1'b0;
      trim_data_o <= '0;
    end else begin
      valid_o <= rd_col_i & cchain[N_COLS];
      if (rd_col_i && cchain[N_COLS]) word_o <= cbus_or[N_COLS];
      if (trim_rd_i && trim_idx < N_CELLS) trim_data_o <= trim_all[trim_idx*TRIM_W +: TRIM_W];
    end
  end
endmodule

// File: rtl/hdr_chk.sv
module hdr_chk #(
  parameter int N_COLS = 4,
  parameter int N_ROWS = 8,
  parameter int TS_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ld_pix_i,
  input logic                     rd_col_i,
  input logic                     valid_o,
  input logic                     empty_o,
  input logic [TS_W-1:0]          ts_q,
  input logic [N_COLS*N_ROWS-1:0] flags,
  input logic [N_COLS-1:0]        buf_v,
  input logic [N_COLS-1:0]        col_grant
);
  import hdr_pkg::*;

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ts_q == TS_W'($past(ts_q) + 1'b1)); // R1
  AST_NO_NEW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !ld_pix_i |=> $countones(flags) <= $countones($past(flags))); // R3
  AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $onehot0(col_grant)); // R5
  AST_COL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    col_grant == N_COLS'(lowest_one(MAX_W'(buf_v)))); // R5
  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    valid_o |-> $past(rd_col_i)); // R6
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_col_i && buf_v == '0) |=> !valid_o); // R7
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    empty_o |-> (buf_v == '0)); // R8
endmodule

bind hdr_top hdr_chk #(.N_COLS(N_COLS), .N_ROWS(N_ROWS), .TS_W(TS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_pix_i (ld_pix_i),
  .rd_col_i (rd_col_i),
  .valid_o  (valid_o),
  .empty_o  (empty_o),
  .ts_q     (ts_q),
  .flags    (flag_all),
  .buf_v    (buf_v),
  .col_grant(col_grant)
);

// File: tb/sim_hdr_top.sv
module sim_hdr_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4, NR = 8, TW = 8, NCELL = 32;
  localparam logic [31:0] PATTERNS [8] = '{
    32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0101_0101,
    32'hA5C3_0F18, 32'h0000_0000, 32'h1234_8001, 32'h80FE_0040
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] hit = '0;
  logic ld_pix = 0, ld_col = 0, rd_col = 0, trim_wr = 0, trim_rd = 0;
  logic [1:0] trim_col = '0;
  logic [2:0] trim_row = '0;
  logic [3:0] trim_din = '0, trim_dout;
  logic [12:0] word;
  logic valid, empty;
  int cyc = 0, checks = 0, errors = 0;
  int exp_ts [NCELL];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  hdr_top u0 (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .ld_pix_i(ld_pix), .ld_col_i(ld_col),
    .rd_col_i(rd_col), .trim_wr_i(trim_wr), .trim_rd_i(trim_rd), .trim_col_i(trim_col),
    .trim_row_i(trim_row), .trim_data_i(trim_din), .trim_data_o(trim_dout),
    .word_o(word), .valid_o(valid), .empty_o(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [12:0] exp_word(input int i);
    return {2'(i / NR), 3'(i % NR), 8'(exp_ts[i])};
  endfunction

  task automatic inject(input logic [31:0] p, input bit record);
    for (int i = 0; i < NCELL; i++) if (p[i] && record) exp_ts[i] = cyc % 256;
    hit = p;
    step();
    hit = '0;
  endtask

  task automatic freeze();
    ld_pix = 1; step(); ld_pix = 0;
  endtask

  task automatic drain(input logic [31:0] p, input string tag);
    logic [12:0] last;
    for (int i = 0; i < NCELL; i++) begin
      if (p[i]) begin
        ld_col = 1; step(); ld_col = 0;
        rd_col = 1; step(); rd_col = 0;
        chk({tag, " R6 valid"}, 32'(valid), 32'd1);
        chk({tag, " R9 R4 R5 word"}, 32'(word), 32'(exp_word(i)));
      end
    end
    chk({tag, " R8 empty after drain"}, 32'(empty), 32'd1);
    last = word;
    ld_col = 1; step(); ld_col = 0;
    rd_col = 1; step(); rd_col = 0;
    chk({tag, " R7 idle read valid"}, 32'(valid), 32'd0);
    chk({tag, " R7 idle read word"}, 32'(word), 32'(last));
  endtask

  task automatic trim_read(input int c, input int r, input logic [3:0] exp);
    trim_col = 2'(c); trim_row = 3'(r); trim_rd = 1; step(); trim_rd = 0;
    chk("R10 trim readback", 32'(trim_dout), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    chk("R11 valid reset", 32'(valid), 0);
    chk("R11 word reset", 32'(word), 0);
    chk("R11 empty reset", 32'(empty), 1);
    chk("R11 trim reset", 32'(trim_dout), 0);
    rst_n = 1;
    step();

    // table walk: two injection cycles per round give distinct stamps
    foreach (PATTERNS[k]) begin
      inject({16'h0, PATTERNS[k][15:0]}, 1);
      inject({PATTERNS[k][31:16], 16'h0}, 1);
      freeze();
      if (PATTERNS[k] != 0) chk("R8 empty while pending", 32'(empty), 0);
      drain(PATTERNS[k], "table");
    end

    // R2: repeated hits on an armed cell keep the first stamp
    inject(32'h0000_0200, 1);
    step(); step();
    inject(32'h0000_0200, 0);
    freeze();
    inject(32'h0000_0200, 0);
    drain(32'h0000_0200, "R2 repeat");
    // the post-freeze repeat re-armed the cell after its read? no: it was flagged, so ignored
    freeze();
    chk("R2 repeat ignored, empty", 32'(empty), 1);

    // R3: hit armed after freeze waits for the next freeze
    inject(32'h0010_0008, 1);
    freeze();
    inject(32'h0002_0000, 1);
    drain(32'h0010_0008, "R3 first");
    chk("R3 late hit unflagged, empty", 32'(empty), 1);
    freeze();
    chk("R3 late hit now pending", 32'(empty), 0);
    drain(32'h0002_0000, "R3 second");

    // R1: stamps across counter wrap
    while ((cyc % 256) != 255) step();
    inject(32'h0000_0020, 1);
    inject(32'h0000_0040, 1);
    chk("R1 wrap stamp high", 32'(exp_ts[5]), 255);
    chk("R1 wrap stamp low", 32'(exp_ts[6]), 0);
    freeze();
    drain(32'h0000_0060, "R1 wrap");

    // R10: trim write and readback
    trim_wr = 1; trim_col = 2'd1; trim_row = 3'd2; trim_din = 4'hA; step();
    trim_col = 2'd3; trim_row = 3'd7; trim_din = 4'h5; step();
    trim_wr = 0;
    trim_read(1, 2, 4'hA);
    trim_read(3, 7, 4'h5);
    trim_read(0, 0, 4'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule